// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block sits in front of a small byte-addressable nonvolatile data array. The array is modelled as a register file whose write takes a programmable number of clock cycles. The block makes accidental writes hard to cause.

A host reaches the block through four byte-wide registers, chosen by a 2-bit select:

| Select | Register |
|---|---|
| 0 | address |
| 1 | data |
| 2 | control |
| 3 | key |

A write can only begin when all of these hold:
- the key register has just received the right two-byte pattern;
- the write-enable bit is set;
- the power-up timer has finished.

A second, external programming port reads and writes the array directly. A code-protect input can shut that port off. Refused attempts on it are recorded in a sticky flag.

Control register bits:

| Bit | Name | Effect |
|---|---|---|
| 0 | read request | requests a read |
| 1 | start | starts a write |
| 2 | write-enable | its value is stored on every control write |

The host polls the busy output, which mirrors the start bit while a write is in flight, to learn when the write has finished.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: After reset the write-enable flag (`wren_o`) is 0. Every host write to the control register (select 2) loads it from bit 2 of the written byte.
- R2: While `pwrt_done` is low, no write reaches the array. This covers a host start and an external write alike.
- R3: A host write starts only if the last two host writes were 0x55 and then 0xAA to the key register (select 3), and the current write goes to the control register with bit 1 set.
- R4: On the clock edge that accepts a start, `busy_o` rises. It stays high for exactly `WR_LAT` cycles. On the edge where it falls, the latched address and data byte are stored in the array.
- R5: While `code_prot` is high, an external read (`x_rd`) returns 0x00 on `x_rdata` one cycle later, and an external write (`x_wr`) leaves the array unchanged. Host reads and writes work as usual.
- R6: A start is refused unless bit 2 (write-enable) is also set in the control byte that requests it.
- R7: A control write with bit 0 set while not busy loads the array byte at the address register into `data_o` on the next cycle. While busy, such a read leaves `data_o` unchanged.
- R8: A control write with bit 2 clear during a write aborts it. The abort clears `busy_o`, leaves the array unchanged and sets `wrerr_o`. `wrerr_o` is cleared by the next accepted start.
- R9: Any external read or write attempt while `code_prot` is high sets `prot_viol`. The flag stays set until reset.
- R10: Any other host write between 0x55 and 0xAA, or between 0xAA and the start, returns the key sequence to idle, so the start is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrt_done | input | 1 | Power-up timer has expired |
| code_prot | input | 1 | Code protection for the external port |
| h_we | input | 1 | Host register write strobe |
| h_sel | input | 2 | Host register select: 0 address, 1 data, 2 control, 3 key |
| h_wdata | input | 8 | Host write byte |
| data_o | output | 8 | Host data register |
| wren_o | output | 1 | Write-enable flag |
| busy_o | output | 1 | Write in progress (start bit readback) |
| wrerr_o | output | 1 | Last write was aborted |
| x_rd | input | 1 | External read strobe |
| x_wr | input | 1 | External write strobe |
| x_addr | input | AW | External address |
| x_wdata | input | 8 | External write byte |
| x_rdata | output | 8 | External read byte, registered |
| prot_viol | output | 1 | Sticky protect-violation flag |

## Verification
The assertions assume that `WR_LAT` is at least 1. They also assume that the host issues at most one register write per cycle and holds `h_sel` and `h_wdata` steady around the sampling edge.

The stimulus drives every input on the falling edge and pulses each strobe for a single cycle. External accesses are never overlapped with the completion edge of a host write, so the outcome of the host-wins rule never needs to be inferred.

Protection and timer inputs change only between transactions. A change therefore never splits a key sequence except where a test intends it.

// File: rtl/nvw_pkg.sv
// Shared constants and types for the guarded byte store controller.
package nvw_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        ARM_IDLE  = 2'd0,
        ARM_HALF  = 2'd1,
        ARM_READY = 2'd2
    } arm_state_e;

    localparam int CTL_RD  = 0;
    localparam int CTL_GO  = 1;
    localparam int CTL_WEN = 2;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvw_unlock.sv
// Key-sequence tracker. Watches every host register write and reports
// "armed" only when the two most recent writes were KEY_FIRST then
// KEY_SECOND to the key register. Assumes one host write per cycle.
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       is_key,
    input  logic [7:0] wbyte,
    output logic       armed
);
    arm_state_e state_q;

    // Advance the key sequence on each host write; anything unexpected drops to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else if (wr_stb) begin
            unique case (state_q)
                ARM_IDLE:  state_q <= (is_key && wbyte == KEY_FIRST)  ? ARM_HALF  : ARM_IDLE;
                ARM_HALF:  state_q <= (is_key && wbyte == KEY_SECOND) ? ARM_READY : ARM_IDLE;
                default:   state_q <= ARM_IDLE;
            endcase
        end
    end

    assign armed = (state_q == ARM_READY);

    // R10: from ready, any host write leaves ready.
    p_arm_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_stb) |=> !armed);
endmodule

// File: rtl/nvw_engine.sv
// Write engine. Latches address and data on start and counts WR_LAT cycles.
// On the last one it raises commit. An abort during the count drops busy and
// sets the error flag without committing. Assumes WR_LAT >= 1.
module nvw_engine #(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int WR_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          busy,
    output logic          wrerr,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    localparam int CW = $clog2(WR_LAT + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WR_LAT);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    // Run the latency countdown, handle abort and latch the write target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            wrerr  <= 1'b0;
            cnt_q  <= '0;
            c_addr <= '0;
            c_data <= '0;
        end else if (busy) begin
            if (abort) begin
                busy  <= 1'b0;
                wrerr <= 1'b1;
            end else if (cnt_q == CNT_ONE) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end else if (start) begin
            busy   <= 1'b1;
            wrerr  <= 1'b0;
            cnt_q  <= CNT_LOAD;
            c_addr <= addr_in;
            c_data <= data_in;
        end
    end

    // Final countdown cycle without abort stores the byte.
    assign commit = busy && !abort && (cnt_q == CNT_ONE);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q >= CNT_ONE && cnt_q <= CNT_LOAD));
    p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (wrerr && !busy));
endmodule

// File: rtl/nvw_array.sv
// Byte array model with two write ports and two combinational read ports.
// Port A (host commit) has priority over port B (external) on a same-address
// collision. Cleared by reset for a deterministic model.
module nvw_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [AW-1:0] waddr_a,
    input  logic [DW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] waddr_b,
    input  logic [DW-1:0] wdata_b,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar row = 0; row < DEPTH; row++) begin : g_row
        // Update one row, giving the host commit priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[row] <= '0;
            end else if (we_a && waddr_a == AW'(row)) begin
                mem[row] <= wdata_a;
            end else if (we_b && waddr_b == AW'(row)) begin
                mem[row] <= wdata_b;
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nvm_guard_ctrl.sv
// Guarded nonvolatile byte store controller (top). Holds the host address,
// data and write-enable registers, gates the external port by code
// protection and the power-up timer, and ties together the key tracker,
// write engine and array. Assumes one host register write per cycle.
module nvm_guard_ctrl
    import nvw_pkg::*;
#(
    parameter int AW     = 4,
    parameter int WR_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrt_done,
    input  logic          code_prot,
    input  logic          h_we,
    input  logic [1:0]    h_sel,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    data_o,
    output logic          wren_o,
    output logic          busy_o,
    output logic          wrerr_o,
    input  logic          x_rd,
    input  logic          x_wr,
    input  logic [AW-1:0] x_addr,
    input  logic [7:0]    x_wdata,
    output logic [7:0]    x_rdata,
    output logic          prot_viol
);
    localparam int DW = 8;

    host_sel_e     sel;
    logic          ctrl_wr, key_wr, armed, start, abort, rd_go;
    logic          commit, x_wr_ok;
    logic [AW-1:0] addr_q, c_addr;
    logic [DW-1:0] data_q, c_data, host_rd, ext_rd;
    logic          wren_q;

    assign sel     = host_sel_e'(h_sel);
    assign ctrl_wr = h_we && (sel == SEL_CTRL);
    assign key_wr  = (sel == SEL_KEY);
    assign start   = ctrl_wr && armed && h_wdata[CTL_GO] && h_wdata[CTL_WEN]
                     && pwrt_done && !busy_o;
    assign abort   = ctrl_wr && !h_wdata[CTL_WEN];
    assign rd_go   = ctrl_wr && h_wdata[CTL_RD] && !busy_o;
    assign x_wr_ok = x_wr && !code_prot && pwrt_done;

    nvw_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (h_we),
        .is_key (key_wr),
        .wbyte  (h_wdata),
        .armed  (armed)
    );

    nvw_engine #(.AW(AW), .DW(DW), .WR_LAT(WR_LAT)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (abort),
        .addr_in (addr_q),
        .data_in (data_q),
        .busy    (busy_o),
        .wrerr   (wrerr_o),
        .commit  (commit),
        .c_addr  (c_addr),
        .c_data  (c_data)
    );

    nvw_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (commit),
        .waddr_a (c_addr),
        .wdata_a (c_data),
        .we_b    (x_wr_ok),
        .waddr_b (x_addr),
        .wdata_b (x_wdata),
        .raddr_a (addr_q),
        .rdata_a (host_rd),
        .raddr_b (x_addr),
        .rdata_b (ext_rd)
    );

    // Host-visible registers: address, data (or read result) and write-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wren_q <= 1'b0;
        end else begin
            if (h_we && sel == SEL_ADDR) addr_q <= h_wdata[AW-1:0];
            if (h_we && sel == SEL_DATA) data_q <= h_wdata;
            if (rd_go)                   data_q <= host_rd;
            if (ctrl_wr)                 wren_q <= h_wdata[CTL_WEN];
        end
    end

    // External read path and sticky violation flag under code protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_rdata   <= '0;
            prot_viol <= 1'b0;
        end else begin
            if (x_rd)                      x_rdata   <= code_prot ? '0 : ext_rd;
            if ((x_rd || x_wr) && code_prot) prot_viol <= 1'b1;
        end
    end

    assign data_o = data_q;
    assign wren_o = wren_q;

    p_start_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(pwrt_done));
    p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(armed));
    p_start_wren_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> wren_q);
    p_prot_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_prot && x_rd) |=> (x_rdata == '0));
    p_read_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctrl_wr) |=> $stable(data_q));
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |=> prot_viol);
endmodule

// File: tb/nvm_guard_ctrl_tb.sv
module nvm_guard_ctrl_tb_top;
    localparam int AW  = 4;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrt_done = 1'b0, code_prot = 1'b0;
    logic h_we = 1'b0;
    logic [1:0] h_sel = 2'd0;
    logic [7:0] h_wdata = 8'h00;
    logic x_rd = 1'b0, x_wr = 1'b0;
    logic [AW-1:0] x_addr = '0;
    logic [7:0] x_wdata = 8'h00;
    logic [7:0] data_o, x_rdata;
    logic wren_o, busy_o, wrerr_o, prot_viol;

    always #5 clk = ~clk;

    nvm_guard_ctrl #(.AW(AW), .WR_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwrt_done(pwrt_done), .code_prot(code_prot),
        .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
        .data_o(data_o), .wren_o(wren_o), .busy_o(busy_o), .wrerr_o(wrerr_o),
        .x_rd(x_rd), .x_wr(x_wr), .x_addr(x_addr), .x_wdata(x_wdata),
        .x_rdata(x_rdata), .prot_viol(prot_viol)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit started = 0;

    // Behavioural reference model
    int m_mem [16];
    int m_key, m_cnt, m_addr, m_data, m_la, m_ld, m_xr;
    bit m_busy, m_wrerr, m_wren, m_viol;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_key = 0; m_cnt = 0; m_addr = 0; m_data = 0; m_la = 0; m_ld = 0; m_xr = 0;
            m_busy = 0; m_wrerr = 0; m_wren = 0; m_viol = 0;
            started = 1;
        end else begin
            bit ob, ctl, cm, go;
            int d;
            d   = int'(h_wdata);
            ob  = m_busy;
            ctl = h_we && h_sel == 2'd2;
            if (x_rd) m_xr = code_prot ? 0 : m_mem[x_addr];
            if ((x_rd || x_wr) && code_prot) m_viol = 1;
            cm = ob && !(ctl && d[2] == 0) && m_cnt == 1;
            if (ctl && d[0] && !ob) m_data = m_mem[m_addr];
            if (h_we && h_sel == 2'd1) m_data = d;
            if (h_we && h_sel == 2'd0) m_addr = d % 16;
            if (ctl) m_wren = d[2];
            go = ctl && m_key == 2 && d[1] && d[2] && pwrt_done && !ob;
            if (ob) begin
                if (ctl && d[2] == 0) begin m_busy = 0; m_wrerr = 1; end
                else if (m_cnt == 1) m_busy = 0;
                else m_cnt--;
            end else if (go) begin
                m_busy = 1; m_cnt = LAT; m_wrerr = 0; m_la = m_addr; m_ld = m_data;
            end
            if (x_wr && !code_prot && pwrt_done) m_mem[x_addr] = int'(x_wdata);
            if (cm) m_mem[m_la] = m_ld;
            if (h_we) begin
                if (m_key == 0)      m_key = (h_sel == 2'd3 && d == 8'h55) ? 1 : 0;
                else if (m_key == 1) m_key = (h_sel == 2'd3 && d == 8'hAA) ? 2 : 0;
                else                 m_key = 0;
            end
        end
    end

    // Compare every port with the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R7 data_o", int'(data_o), m_data);
            chk("R1 wren_o", int'(wren_o), int'(m_wren));
            chk("R4 busy_o", int'(busy_o), int'(m_busy));
            chk("R8 wrerr_o", int'(wrerr_o), int'(m_wrerr));
            chk("R5 x_rdata", int'(x_rdata), m_xr);
            chk("R9 prot_viol", int'(prot_viol), int'(m_viol));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic hw(input logic [1:0] s, input logic [7:0] d);
        h_we = 1'b1; h_sel = s; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic keyed(input logic [7:0] c);
        hw(2'd3, 8'h55); hw(2'd3, 8'hAA); hw(2'd2, c);
    endtask

    task automatic hread(input logic [3:0] a);
        hw(2'd0, {4'h0, a}); hw(2'd2, 8'h05);
    endtask

    task automatic xop(input bit wr, input logic [3:0] a, input logic [7:0] d);
        x_rd = !wr; x_wr = wr; x_addr = a; x_wdata = d;
        @(negedge clk);
        x_rd = 1'b0; x_wr = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset wren", int'(wren_o), 0);
        chk("R4 reset busy", int'(busy_o), 0);

        // R2: timer still running, start refused
        hw(2'd0, 8'h03); hw(2'd1, 8'h3C); hw(2'd2, 8'h04);
        chk("R1 wren set", int'(wren_o), 1);
        keyed(8'h06);
        chk("R2 no start", int'(busy_o), 0);
        xop(1, 4'd2, 8'h44);
        hread(4'd3);
        chk("R2 host blocked", int'(data_o), 0);
        hread(4'd2);
        chk("R2 ext blocked", int'(data_o), 0);

        // R3/R4: full sequence
        pwrt_done = 1'b1;
        hw(2'd0, 8'h03); hw(2'd1, 8'h3C);
        keyed(8'h06);
        chk("R3 started", int'(busy_o), 1);
        idle(LAT - 1);
        chk("R4 still busy", int'(busy_o), 1);
        idle(1);
        chk("R4 done", int'(busy_o), 0);
        hread(4'd3);
        chk("R4 stored", int'(data_o), 8'h3C);

        // R10: broken sequences
        hw(2'd0, 8'h05); hw(2'd1, 8'h11);
        hw(2'd3, 8'h55); hw(2'd0, 8'h05); hw(2'd3, 8'hAA); hw(2'd2, 8'h06);
        chk("R10 gap first", int'(busy_o), 0);
        hw(2'd3, 8'h55); hw(2'd3, 8'hAA); hw(2'd1, 8'h11); hw(2'd2, 8'h06);
        chk("R10 gap second", int'(busy_o), 0);
        // R6: write-enable clear in start byte
        keyed(8'h02);
        chk("R6 no start", int'(busy_o), 0);
        chk("R1 wren cleared", int'(wren_o), 0);
        hread(4'd5);
        chk("R10 untouched", int'(data_o), 0);

        // R7: read refused while busy
        hw(2'd0, 8'h09); hw(2'd1, 8'h5A);
        keyed(8'h06);
        hw(2'd2, 8'h05);
        chk("R7 read refused", int'(data_o), 8'h5A);
        idle(LAT);
        hw(2'd2, 8'h05);
        chk("R7 read after", int'(data_o), 8'h5A);

        // R8: abort
        hw(2'd0, 8'h0A); hw(2'd1, 8'h99);
        keyed(8'h06);
        hw(2'd2, 8'h00);
        chk("R8 aborted", int'(busy_o), 0);
        chk("R8 wrerr", int'(wrerr_o), 1);
        idle(LAT);
        hread(4'd10);
        chk("R8 unchanged", int'(data_o), 0);
        hw(2'd1, 8'h21); keyed(8'h06);
        chk("R8 wrerr cleared", int'(wrerr_o), 0);
        idle(LAT + 1);

        // R5/R9: external port
        xop(1, 4'd7, 8'h77);
        xop(0, 4'd7, 8'h00);
        chk("R5 ext read", int'(x_rdata), 8'h77);
        code_prot = 1'b1;
        xop(0, 4'd7, 8'h00);
        chk("R5 prot read", int'(x_rdata), 0);
        chk("R9 viol", int'(prot_viol), 1);
        xop(1, 4'd7, 8'hEE);
        hread(4'd7);
        chk("R5 host read", int'(data_o), 8'h77);
        hw(2'd1, 8'hC3); keyed(8'h06); idle(LAT + 1);
        hread(4'd7);
        chk("R5 host write", int'(data_o), 8'hC3);
        code_prot = 1'b0;
        idle(2);
        chk("R9 sticky", int'(prot_viol), 1);
        xop(0, 4'd7, 8'h00);
        chk("R5 ext after", int'(x_rdata), 8'hC3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule